// File: doc/BRIEF.md
# Sixteen-Bit ALU With Overflow Word

This block performs the two-operand arithmetic and logic operations of a small 16-bit processor and keeps a dedicated overflow word (O) beside them. The caller presents two operand values, a 4-bit operation code and a flag that says whether the destination is a literal, then pulses `start`. The block returns the result, a write strobe for the destination, the architectural cycle cost of the operation, and the updated O word.

Each operation leaves its own extension value in O. Add leaves the carry, subtract leaves a borrow mask, multiply leaves the upper product half, and divide leaves the fractional quotient. Shifts leave the bits that were shifted out. Most operations finish one clock after `start`. Divide and modulo use a bit-serial restoring divider and finish after 2W+1 clocks. Division by zero gives zero.

Top module: `ovf_alu`

## Requirements
- R1: After reset, `done`, `busy` and `wr_en` are 0, and `result` and `o_val` are 0.
- R2: The operation codes are 2 ADD, 3 SUB, 4 MUL, 5 DIV, 6 MOD, 7 SHL, 8 SHR, 9 AND, 10 OR and 11 XOR. Any other code completes with `wr_en` 0, cost 0 and O unchanged. ADD returns (a+b) mod 2^16 and sets O to 1 on a carry out of bit 15, otherwise to 0.
- R3: SUB returns (a-b) mod 2^16 and sets O to 0xffff when b > a, otherwise to 0.
- R4: MUL returns the low 16 bits of a*b and puts the high 16 bits in O.
- R5: DIV returns a/b and sets O to ((a<<16)/b) & 0xffff. When b is 0, both the result and O are 0.
- R6: MOD returns a%b, or 0 when b is 0. It leaves O unchanged.
- R7: SHL returns (a<<b) & 0xffff and sets O to ((a<<b)>>16) & 0xffff. SHR returns a>>b and sets O to ((a<<16)>>b) & 0xffff. A count of 16 or more gives a zero result. O is 0 once the count reaches 32.
- R8: AND, OR and XOR return the bitwise result and leave O unchanged.
- R9: `cost` is 2 for ADD, SUB, MUL, SHL and SHR, 3 for DIV and MOD, and 1 for AND, OR and XOR.
- R10: When `dst_lit` is 1 at start, `wr_en` stays 0. O is still updated as for a normal write.
- R11: Non-divide operations raise `done` one clock after `start` is sampled. DIV and MOD raise it 2W+1 clocks after. `done` is a one-cycle pulse per accepted start, and `wr_en` is only ever high together with `done`.
- R12: `start` is ignored while `busy` is high. `result`, `cost` and `o_val` hold their values until the next accepted start completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept an operation this cycle |
| op | input | 4 | Operation code |
| a | input | 16 | First operand (destination value) |
| b | input | 16 | Second operand |
| dst_lit | input | 1 | Destination is a literal, so suppress the write |
| busy | output | 1 | Divider running |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Write the result to the destination |
| o_val | output | 16 | Overflow word |
| cost | output | 2 | Architectural cycle cost |

## Verification
Random operands cover every operation. The shift counts are drawn from 0 to 40 so that both the in-range and out-of-range branches of R7 are used, and divisors are sometimes forced to zero. Directed cases isolate the operand values that separate a correct extension word from a near miss: an all-ones add that carries, a subtract that borrows by one, an all-ones square, a one-third fraction, and shifts by exactly 16 and 32. A logic operation run after an O-writing operation shows whether O is wrongly overwritten. A literal destination shows whether the write is suppressed while O still updates. A start issued mid-divide shows whether a busy divider can be disturbed.

// File: rtl/ovf_alu.sv
module ovf_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         dst_lit,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [W-1:0] o_val,
  output logic [1:0]   cost
);
  localparam int CW = $clog2(2*W);
  localparam logic [3:0] OP_ADD = 4'h2, OP_SUB = 4'h3, OP_MUL = 4'h4, OP_DIV = 4'h5,
                         OP_MOD = 4'h6, OP_SHL = 4'h7, OP_SHR = 4'h8, OP_AND = 4'h9,
                         OP_OR  = 4'hA, OP_XOR = 4'hB;

  wire accept = start && !busy;
  wire is_div = (op == OP_DIV) || (op == OP_MOD);

  logic [W:0]     sum, diff;
  logic [2*W-1:0] prod, shl_w, shr_w;
  assign sum   = {1'b0, a} + {1'b0, b};
  assign diff  = {1'b0, a} - {1'b0, b};
  assign prod  = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign shl_w = {{W{1'b0}}, a} << b;
  assign shr_w = {a, {W{1'b0}}} >> b;

  logic [W-1:0] n_res, n_o;
  logic         n_oupd, n_wr;
  logic [1:0]   n_cost;
  always_comb begin
    n_res = '0; n_o = '0; n_oupd = 1'b0; n_wr = 1'b1; n_cost = 2'd2;
    case (op)
      OP_ADD: begin n_res = sum[W-1:0];  n_o = {{(W-1){1'b0}}, sum[W]}; n_oupd = 1'b1; end
      OP_SUB: begin n_res = diff[W-1:0]; n_o = {W{diff[W]}};            n_oupd = 1'b1; end
      OP_MUL: begin n_res = prod[W-1:0]; n_o = prod[2*W-1:W];           n_oupd = 1'b1; end
      OP_SHL: begin n_res = shl_w[W-1:0];   n_o = shl_w[2*W-1:W];       n_oupd = 1'b1; end
      OP_SHR: begin n_res = shr_w[2*W-1:W]; n_o = shr_w[W-1:0];         n_oupd = 1'b1; end
      OP_AND: begin n_res = a & b; n_cost = 2'd1; end
      OP_OR:  begin n_res = a | b; n_cost = 2'd1; end
      OP_XOR: begin n_res = a ^ b; n_cost = 2'd1; end
      default: begin n_wr = 1'b0; n_cost = 2'd0; end
    endcase
  end

  logic [2*W-1:0] dq;
  logic [W-1:0]   rem, bq, mod_r;
  logic [CW-1:0]  cnt;
  logic           mod_q, lit_q;
  logic [W:0]     t, tsub;
  logic           ge;
  logic [W-1:0]   rem_n;
  logic [2*W-1:0] dq_n;
  assign t     = {rem, dq[2*W-1]};
  assign tsub  = t - {1'b0, bq};
  assign ge    = t >= {1'b0, bq};
  assign rem_n = ge ? tsub[W-1:0] : t[W-1:0];
  assign dq_n  = {dq[2*W-2:0], ge};
  wire   bz    = (bq == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; wr_en <= 1'b0; result <= '0; o_val <= '0; cost <= '0;
      dq <= '0; rem <= '0; bq <= '0; mod_r <= '0; cnt <= '0; mod_q <= 1'b0; lit_q <= 1'b0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (busy) begin
        dq  <= dq_n;
        rem <= rem_n;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W-1)) mod_r <= rem_n;
        if (cnt == CW'(2*W-1)) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          wr_en <= !lit_q;
          cost  <= 2'd3;
          if (mod_q) result <= bz ? '0 : mod_r;
          else begin
            result <= bz ? '0 : dq_n[2*W-1:W];
            o_val  <= bz ? '0 : dq_n[W-1:0];
          end
        end
      end else if (accept) begin
        if (is_div) begin
          busy  <= 1'b1;
          dq    <= {a, {W{1'b0}}};
          rem   <= '0;
          bq    <= b;
          cnt   <= '0;
          mod_q <= (op == OP_MOD);
          lit_q <= dst_lit;
        end else begin
          done   <= 1'b1;
          wr_en  <= n_wr && !dst_lit;
          result <= n_res;
          cost   <= n_cost;
          if (n_oupd) o_val <= n_o;
        end
      end
    end
  end

  a_r11_wr_with_done: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> done);
  a_r11_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !done);
  a_r11_div_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (op == OP_DIV || op == OP_MOD)) |=> (busy && !done));
  a_r8_logic_keeps_o: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> $stable(o_val));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(o_val) && $stable(cost)));
endmodule

// File: tb/sim_ovf_alu.sv
module sim_ovf_alu;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dst_lit = 1'b0;
  logic [3:0] op = '0;
  logic [15:0] a = '0, b = '0;
  logic busy, done, wr_en;
  logic [15:0] result, o_val;
  logic [1:0] cost;
  int checks = 0, fails = 0;
  logic [15:0] exp_o = '0;

  ovf_alu #(.W(16)) u0 (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
    .dst_lit(dst_lit), .busy(busy), .done(done), .result(result), .wr_en(wr_en),
    .o_val(o_val), .cost(cost));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'h2: return "R2"; 4'h3: return "R3"; 4'h4: return "R4"; 4'h5: return "R5";
      4'h6: return "R6"; 4'h7: return "R7"; 4'h8: return "R7";
      default: return "R8";
    endcase
  endfunction

  // expected result, O update flag/value, cost
  task automatic model(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                       output logic [15:0] r, output bit upd, output logic [15:0] ov,
                       output int c);
    longint lx = longint'(x), ly = longint'(y);
    upd = 1; ov = 0; r = 0; c = 2;
    case (o)
      4'h2: begin r = 16'((lx + ly) & 64'hffff); ov = (lx + ly > 65535) ? 16'h1 : 16'h0; end
      4'h3: begin r = 16'((lx - ly) & 64'hffff); ov = (ly > lx) ? 16'hffff : 16'h0; end
      4'h4: begin r = 16'((lx * ly) & 64'hffff); ov = 16'((lx * ly) >> 16); end
      4'h5: begin c = 3; if (ly != 0) begin r = 16'(lx / ly); ov = 16'(((lx << 16) / ly) & 64'hffff); end end
      4'h6: begin c = 3; upd = 0; if (ly != 0) r = 16'(lx % ly); end
      4'h7: begin
        r  = (ly >= 16) ? 16'h0 : 16'((lx << ly) & 64'hffff);
        ov = (ly >= 32) ? 16'h0 : 16'(((lx << ly) >> 16) & 64'hffff);
      end
      4'h8: begin
        r  = (ly >= 16) ? 16'h0 : 16'(lx >> ly);
        ov = (ly >= 32) ? 16'h0 : 16'(((lx << 16) >> ly) & 64'hffff);
      end
      4'h9: begin upd = 0; c = 1; r = x & y; end
      4'hA: begin upd = 0; c = 1; r = x | y; end
      4'hB: begin upd = 0; c = 1; r = x ^ y; end
      default: begin upd = 0; c = 0; end
    endcase
  endtask

  task automatic run(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                     input bit lit, input string tag);
    logic [15:0] er, eo; bit upd; int ec; int lat; bit wr_seen;
    model(o, x, y, er, upd, eo, ec);
    if (upd) exp_o = eo;
    @(negedge clk); op = o; a = x; b = y; dst_lit = lit; start = 1'b1;
    @(posedge clk); lat = 1;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 100) begin @(posedge clk); lat++; @(negedge clk); end
    wr_seen = wr_en;
    check(result == er, tag, result, er);
    check(o_val == exp_o, tag, o_val, exp_o);
    check(int'(cost) == ec, "R9", cost, ec);
    check(wr_seen == (!lit && ec != 0), "R10", wr_seen, !lit && ec != 0);
    check(lat == ((o == 4'h5 || o == 4'h6) ? 33 : 1), "R11", lat, (o == 4'h5 || o == 4'h6) ? 33 : 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [3:0] ops [10] = '{4'h2,4'h3,4'h4,4'h5,4'h6,4'h7,4'h8,4'h9,4'hA,4'hB};
    logic [15:0] keep_r, keep_o;
    int lat;
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !busy && !wr_en, "R1", {done, busy, wr_en}, 0);
    check(result == 0 && o_val == 0, "R1", {result, o_val}, 0);
    rst_n = 1'b1;

    run(4'h2, 16'hffff, 16'h0001, 0, "R2");
    run(4'h2, 16'h1234, 16'h0001, 0, "R2");
    run(4'h3, 16'h0000, 16'h0001, 0, "R3");
    run(4'h3, 16'h0005, 16'h0005, 0, "R3");
    run(4'h4, 16'hffff, 16'hffff, 0, "R4");
    run(4'h9, 16'hf0f0, 16'h3c3c, 0, "R8");
    run(4'hB, 16'hf0f0, 16'h3c3c, 0, "R8");
    run(4'h5, 16'h0001, 16'h0003, 0, "R5");
    run(4'h5, 16'h1234, 16'h0000, 0, "R5");
    run(4'h4, 16'h0100, 16'h0100, 0, "R4");
    run(4'h6, 16'h0064, 16'h0007, 0, "R6");
    run(4'h6, 16'h0064, 16'h0000, 0, "R6");
    run(4'h7, 16'h8001, 16'h0001, 0, "R7");
    run(4'h7, 16'h1234, 16'h0010, 0, "R7");
    run(4'h7, 16'h1234, 16'h0014, 0, "R7");
    run(4'h8, 16'h1234, 16'h0010, 0, "R7");
    run(4'h8, 16'h1234, 16'h0020, 0, "R7");
    run(4'h8, 16'h1235, 16'h0004, 0, "R7");
    run(4'h2, 16'hffff, 16'h0002, 1, "R10");
    run(4'h5, 16'h0064, 16'h0007, 1, "R10");
    run(4'h0, 16'h1111, 16'h2222, 0, "R2");

    // start during a divide is ignored; done is a single pulse; outputs hold
    @(negedge clk); op = 4'h5; a = 16'd100; b = 16'd7; dst_lit = 0; start = 1'b1;
    @(posedge clk); lat = 1;
    @(negedge clk); start = 1'b0;
    repeat (3) begin @(posedge clk); lat++; @(negedge clk); end
    op = 4'h2; a = 16'h0001; b = 16'h0001; start = 1'b1;
    @(posedge clk); lat++;
    @(negedge clk); start = 1'b0;
    check(!done && busy, "R12", {done, busy}, 1);
    while (!done && lat < 100) begin @(posedge clk); lat++; @(negedge clk); end
    exp_o = 16'(((64'd100 << 16) / 64'd7) & 64'hffff);
    check(lat == 33, "R12", lat, 33);
    check(result == 16'd14, "R12", result, 14);
    check(o_val == exp_o, "R12", o_val, exp_o);
    keep_r = result; keep_o = o_val;
    @(posedge clk); @(negedge clk);
    check(!done && !wr_en, "R11", {done, wr_en}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(result == keep_r && o_val == keep_o, "R12", {result, o_val}, {keep_r, keep_o});

    for (int i = 0; i < 300; i++) begin
      logic [3:0] o; logic [15:0] x, y;
      o = ops[$urandom_range(0, 9)];
      x = 16'($urandom());
      y = 16'($urandom());
      if (o == 4'h7 || o == 4'h8) y = 16'($urandom_range(0, 40));
      if ((o == 4'h5 || o == 4'h6) && $urandom_range(0, 7) == 0) y = 16'h0;
      run(o, x, y, $urandom_range(0, 5) == 0, tag_of(o));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule